// File: doc/BRIEF.md
# Event Frame Builder with Parity

This block turns one trigger into a framed event for a readout link. When a request is taken, it latches the global crossing ID, the global event count and the number of contributing nodes. It also latches a bitmap that marks every node whose own short counters disagree with the global ones. It then writes a fixed sequence of 32-bit words into a downstream FIFO:

- a start constant;
- four header words (crossing ID, event count, mismatch bitmap, node count);
- two payload words per node;
- a parity word that XORs everything after the start constant;
- an end constant.

A full frame holds 7 + 2N words, where N is the node count. The FIFO's full flag holds emission in place without losing the parity sum. A new request is accepted only once the end constant has gone out.

The controller is an enumerated state machine with the states IDLE, SOF, BCID, EVCNT, ERRMAP, COUNT, NODE_LO, NODE_HI, PARITY and EOF. Its transitions are:

- IDLE→SOF when a request arrives.
- SOF→BCID→EVCNT→ERRMAP→COUNT, one step per written word.
- COUNT→NODE_LO when N>0, or COUNT→PARITY when N=0.
- NODE_LO→NODE_HI.
- NODE_HI→NODE_LO for the next node, or NODE_HI→PARITY after the last node.
- PARITY→EOF, then EOF→IDLE.

Every non-IDLE state advances only in a cycle where a word is written.

Node records must be held stable from acceptance until the block returns to IDLE. Node i occupies the following fields:

- `node_data[i*64 +: 64]`
- `node_bc[i*4 +: 4]`
- `node_ev[i*3 +: 3]`
- `node_valid[i]`

Top module: `evt_frame_builder`

## Requirements
- R1: After reset, `evt_ready` is 1 and `word_we` is 0.
- R2: `evt_req` is taken only in a cycle where `evt_ready` is 1. `evt_ready` is 0 from the next cycle until the cycle after the end word is written. Requests and changes to the global inputs while busy have no effect on the frame in progress.
- R3: The first word of every frame is 0xB0F00000.
- R4: Word 2 is the latched 12-bit crossing ID in bits 11:0, and word 3 is the latched 24-bit event count in bits 23:0. All upper bits are zero.
- R5: Word 4 bit i (for i < N) is 1 when any of these holds: node i is not valid, `node_bc` of node i differs from crossing ID bits 3:0, or `node_ev` of node i differs from event count bits 2:0. Bits at positions N and above are 0.
- R6: Word 5 holds N in bits 7:0, with upper bits zero. N is `nodes_in` clamped to MAX_NODES.
- R7: Nodes 0..N-1 follow in ascending order. Each node gives its low 32 bits, then its high 32 bits. An invalid node gives two zero words.
- R8: The word at position 6+2N is the XOR of words 2 through 5+2N.
- R9: The word at position 7+2N is 0xE0F00000 and is the last word of the frame. The frame holds exactly 7+2N words.
- R10: `word_we` is never 1 while `fifo_full` is 1. Stalls do not change the content of the frame.
- R11: Without stalls, one word is written per cycle, so the block is busy for exactly 7+2N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_req | input | 1 | Request to build a frame |
| evt_ready | output | 1 | Idle, request can be taken |
| bcid_in | input | BCID_W | Global crossing ID |
| evcnt_in | input | EVCNT_W | Global event count |
| nodes_in | input | NCNT_W | Requested node count |
| node_valid | input | MAX_NODES | Per-node record valid |
| node_bc | input | MAX_NODES*LBC_W | Per-node local crossing counter |
| node_ev | input | MAX_NODES*LEV_W | Per-node local trigger counter |
| node_data | input | MAX_NODES*64 | Per-node 64-bit record |
| fifo_full | input | 1 | Downstream FIFO full |
| word_we | output | 1 | Output word write strobe |
| word_out | output | 32 | Output word |

## Verification
The bench builds the block with MAX_NODES = 4 and keeps the counter widths at their defaults. This makes it practical to sweep every node count from 0 to 4, plus requests of 5 and 6 that must clamp. It also covers all sixteen crossing-mismatch masks on a full set of four nodes, with varying event mismatches and invalid nodes. Every frame word, including the parity word, is recomputed arithmetically in the bench. Frames are repeated under a pseudo-random full flag and with requests injected mid-frame, which exercises stall hold and the busy lockout.

// File: rtl/efb_pkg.sv
package efb_pkg;

    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] SOF_WORD = 32'hB0F0_0000;
    localparam logic [WORD_W-1:0] EOF_WORD = 32'hE0F0_0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SOF,
        ST_BCID,
        ST_EVCNT,
        ST_ERRMAP,
        ST_COUNT,
        ST_NODE_LO,
        ST_NODE_HI,
        ST_PARITY,
        ST_EOF
    } efb_state_e;

endpackage

// File: rtl/efb_mismatch.sv
module efb_mismatch #(
    parameter int MAX_NODES = 25,
    parameter int LBC_W     = 4,
    parameter int LEV_W     = 3,
    parameter int NCNT_W    = 8
) (
    input  logic [MAX_NODES*LBC_W-1:0] node_bc,
    input  logic [MAX_NODES*LEV_W-1:0] node_ev,
    input  logic [MAX_NODES-1:0]       node_valid,
    input  logic [LBC_W-1:0]           ref_bc,
    input  logic [LEV_W-1:0]           ref_ev,
    input  logic [NCNT_W-1:0]          count,
    output logic [MAX_NODES-1:0]       err_map
);

    // One comparator per node slot; slots at or past the count stay clear.
    for (genvar g = 0; g < MAX_NODES; g++) begin : g_node
        localparam logic [NCNT_W-1:0] SLOT = NCNT_W'(g);
        logic bc_diff;
        logic ev_diff;
        assign bc_diff    = node_bc[g*LBC_W +: LBC_W] != ref_bc;
        assign ev_diff    = node_ev[g*LEV_W +: LEV_W] != ref_ev;
        assign err_map[g] = (SLOT < count) && (!node_valid[g] || bc_diff || ev_diff);
    end

endmodule

// File: rtl/efb_word_sel.sv
module efb_word_sel
    import efb_pkg::*;
#(
    parameter int MAX_NODES = 25,
    parameter int BCID_W    = 12,
    parameter int EVCNT_W   = 24,
    parameter int NCNT_W    = 8
) (
    input  efb_state_e              state,
    input  logic [BCID_W-1:0]       bcid,
    input  logic [EVCNT_W-1:0]      evcnt,
    input  logic [MAX_NODES-1:0]    err_map,
    input  logic [NCNT_W-1:0]       nodes,
    input  logic [2*WORD_W-1:0]     node_rec,
    input  logic [WORD_W-1:0]       parity,
    output logic [WORD_W-1:0]       word
);

    always_comb begin
        unique case (state)
            ST_SOF:     word = SOF_WORD;
            ST_BCID:    word = WORD_W'(bcid);
            ST_EVCNT:   word = WORD_W'(evcnt);
            ST_ERRMAP:  word = WORD_W'(err_map);
            ST_COUNT:   word = WORD_W'(nodes);
            ST_NODE_LO: word = node_rec[WORD_W-1:0];
            ST_NODE_HI: word = node_rec[2*WORD_W-1:WORD_W];
            ST_PARITY:  word = parity;
            ST_EOF:     word = EOF_WORD;
            default:    word = '0;
        endcase
    end

endmodule

// File: rtl/evt_frame_builder.sv
module evt_frame_builder
    import efb_pkg::*;
#(
    parameter int MAX_NODES = 25,
    parameter int BCID_W    = 12,
    parameter int EVCNT_W   = 24,
    parameter int NCNT_W    = 8,
    parameter int LBC_W     = 4,
    parameter int LEV_W     = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           evt_req,
    output logic                           evt_ready,
    input  logic [BCID_W-1:0]              bcid_in,
    input  logic [EVCNT_W-1:0]             evcnt_in,
    input  logic [NCNT_W-1:0]              nodes_in,
    input  logic [MAX_NODES-1:0]           node_valid,
    input  logic [MAX_NODES*LBC_W-1:0]     node_bc,
    input  logic [MAX_NODES*LEV_W-1:0]     node_ev,
    input  logic [MAX_NODES*2*WORD_W-1:0]  node_data,
    input  logic                           fifo_full,
    output logic                           word_we,
    output logic [WORD_W-1:0]              word_out
);

    localparam int NODE_W = 2 * WORD_W;
    localparam int IDX_W  = (MAX_NODES > 1) ? $clog2(MAX_NODES) : 1;

    efb_state_e             state_q, state_d;
    logic [IDX_W-1:0]       idx_q;
    logic [BCID_W-1:0]      bcid_q;
    logic [EVCNT_W-1:0]     evcnt_q;
    logic [MAX_NODES-1:0]   err_q;
    logic [MAX_NODES-1:0]   err_d;
    logic [NCNT_W-1:0]      nodes_q;
    logic [NCNT_W-1:0]      nodes_clamp;
    logic [WORD_W-1:0]      parity_q;
    logic [WORD_W-1:0]      cur_word;
    logic [NODE_W-1:0]      cur_node;
    logic [NODE_W-1:0]      rec [MAX_NODES];
    logic                   accept;
    logic                   emit;
    logic                   last_node;

    // Requested count saturates at the number of node slots.
    assign nodes_clamp = (nodes_in > NCNT_W'(MAX_NODES)) ? NCNT_W'(MAX_NODES) : nodes_in;

    efb_mismatch #(
        .MAX_NODES (MAX_NODES),
        .LBC_W     (LBC_W),
        .LEV_W     (LEV_W),
        .NCNT_W    (NCNT_W)
    ) mismatch_i (
        .node_bc    (node_bc),
        .node_ev    (node_ev),
        .node_valid (node_valid),
        .ref_bc     (bcid_in[LBC_W-1:0]),
        .ref_ev     (evcnt_in[LEV_W-1:0]),
        .count      (nodes_clamp),
        .err_map    (err_d)
    );

    for (genvar g = 0; g < MAX_NODES; g++) begin : g_rec
        assign rec[g] = node_data[g*NODE_W +: NODE_W];
    end

    // Invalid records contribute zero payload.
    assign cur_node = node_valid[idx_q] ? rec[idx_q] : '0;

    efb_word_sel #(
        .MAX_NODES (MAX_NODES),
        .BCID_W    (BCID_W),
        .EVCNT_W   (EVCNT_W),
        .NCNT_W    (NCNT_W)
    ) word_sel_i (
        .state    (state_q),
        .bcid     (bcid_q),
        .evcnt    (evcnt_q),
        .err_map  (err_q),
        .nodes    (nodes_q),
        .node_rec (cur_node),
        .parity   (parity_q),
        .word     (cur_word)
    );

    // Output process.
    always_comb begin
        evt_ready = (state_q == ST_IDLE);
        word_we   = (state_q != ST_IDLE) && !fifo_full;
        word_out  = cur_word;
    end

    assign accept    = evt_ready && evt_req;
    assign emit      = word_we;
    assign last_node = (NCNT_W'(idx_q) + NCNT_W'(1)) == nodes_q;

    // Next-state logic: every busy state waits for a written word.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (evt_req) state_d = ST_SOF;
            ST_SOF:     if (emit) state_d = ST_BCID;
            ST_BCID:    if (emit) state_d = ST_EVCNT;
            ST_EVCNT:   if (emit) state_d = ST_ERRMAP;
            ST_ERRMAP:  if (emit) state_d = ST_COUNT;
            ST_COUNT:   if (emit) state_d = (nodes_q == '0) ? ST_PARITY : ST_NODE_LO;
            ST_NODE_LO: if (emit) state_d = ST_NODE_HI;
            ST_NODE_HI: if (emit) state_d = last_node ? ST_PARITY : ST_NODE_LO;
            ST_PARITY:  if (emit) state_d = ST_EOF;
            ST_EOF:     if (emit) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame context: latched at acceptance, advanced on each written word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            bcid_q   <= '0;
            evcnt_q  <= '0;
            err_q    <= '0;
            nodes_q  <= '0;
            parity_q <= '0;
        end else if (accept) begin
            idx_q    <= '0;
            bcid_q   <= bcid_in;
            evcnt_q  <= evcnt_in;
            err_q    <= err_d;
            nodes_q  <= nodes_clamp;
            parity_q <= '0;
        end else if (emit) begin
            if (state_q inside {ST_BCID, ST_EVCNT, ST_ERRMAP, ST_COUNT, ST_NODE_LO, ST_NODE_HI}) begin
                parity_q <= parity_q ^ cur_word;
            end
            if (state_q == ST_NODE_HI) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/efb_checker.sv
module efb_checker
    import efb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_req,
    input logic              evt_ready,
    input logic              fifo_full,
    input logic              word_we,
    input logic [WORD_W-1:0] word_out
);

    logic first_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_pend <= 1'b0;
        end else if (evt_req && evt_ready) begin
            first_pend <= 1'b1;
        end else if (word_we) begin
            first_pend <= 1'b0;
        end
    end

    // R10
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |-> !fifo_full);

    // R2
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ready |-> !word_we);

    // R2
    busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_ready) |-> $past(evt_req));

    // R3
    start_word_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pend && word_we) |-> (word_out == SOF_WORD));

    // R9
    end_word_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_ready) |-> ($past(word_we) && $past(word_out) == EOF_WORD));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_ready && $past(!evt_ready) && $past(fifo_full)) |-> $stable(word_out));

endmodule

bind evt_frame_builder efb_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_req   (evt_req),
    .evt_ready (evt_ready),
    .fifo_full (fifo_full),
    .word_we   (word_we),
    .word_out  (word_out)
);

// File: tb/evt_frame_builder_tb_top.sv
`timescale 1ns/1ps
module evt_frame_builder_tb_top;

    localparam int NN = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            evt_req = 1'b0;
    logic            evt_ready;
    logic [11:0]     bcid_in = '0;
    logic [23:0]     evcnt_in = '0;
    logic [7:0]      nodes_in = '0;
    logic [NN-1:0]   node_valid = '0;
    logic [NN*4-1:0] node_bc = '0;
    logic [NN*3-1:0] node_ev = '0;
    logic [NN*64-1:0] node_data = '0;
    logic            fifo_full = 1'b0;
    logic            word_we;
    logic [31:0]     word_out;

    int checks = 0;
    int errors = 0;
    int gcnt = 0;
    int cycles = 0;
    int frame_no = 0;
    logic [31:0] got [0:63];
    logic [31:0] exp_w [0:63];
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #2 clk = ~clk;

    evt_frame_builder #(.MAX_NODES(NN)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_ready(evt_ready),
        .bcid_in(bcid_in), .evcnt_in(evcnt_in), .nodes_in(nodes_in),
        .node_valid(node_valid), .node_bc(node_bc), .node_ev(node_ev),
        .node_data(node_data), .fifo_full(fifo_full),
        .word_we(word_we), .word_out(word_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s frame %0d: actual %h expected %h", tag, frame_no, act, expv);
        end
    endtask

    // Stall pattern driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        fifo_full = stall_en && (lfsr[1:0] == 2'b00 || lfsr[2:0] == 3'b111);
    end

    // Collect written words away from the rising edge.
    always @(negedge clk) begin
        cycles++;
        if (word_we) begin
            if (fifo_full) check(1'b0, "R10 write while full", 32'd1, 32'd0);
            if (gcnt < 64) got[gcnt] = word_out;
            gcnt++;
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic string tag_of(input int k, input int len);
        if (k == 0) return "R3 start word";
        if (k == 1 || k == 2) return "R4 header";
        if (k == 3) return "R5 mismatch map";
        if (k == 4) return "R6 node count";
        if (k == len - 2) return "R8 parity";
        if (k == len - 1) return "R9 end word";
        return "R7 node payload";
    endfunction

    task automatic run_frame(input int n, input logic [3:0] bcm, input logic [3:0] evm,
                             input logic [3:0] vld, input bit stall, input bit poke);
        int nc;
        int len;
        int busy;
        logic [11:0] bc_l;
        logic [23:0] ev_l;
        logic [31:0] par;
        logic [3:0]  emap;
        frame_no++;
        nc  = (n > NN) ? NN : n;
        len = 7 + 2 * nc;
        bc_l = 12'(frame_no * 37 + 5);
        ev_l = 24'(frame_no * 1021 + 3);
        bcid_in  = bc_l;
        evcnt_in = ev_l;
        nodes_in = 8'(n);
        node_valid = vld;
        for (int i = 0; i < NN; i++) begin
            node_bc[i*4 +: 4]    = bc_l[3:0] ^ (bcm[i] ? 4'h9 : 4'h0);
            node_ev[i*3 +: 3]    = ev_l[2:0] ^ (evm[i] ? 3'h4 : 3'h0);
            node_data[i*64 +: 32] = {8'(frame_no), 8'(i), 16'hC3A5 ^ 16'(frame_no * 7)};
            node_data[i*64+32 +: 32] = ~{8'(frame_no), 8'(i), 16'h5A3C} ^ 32'(i * 3 + 1);
        end
        emap = '0;
        for (int i = 0; i < NN; i++) begin
            if (i < nc) emap[i] = !vld[i] || bcm[i] || evm[i];
        end
        exp_w[0] = 32'hB0F0_0000;
        exp_w[1] = {20'h0, bc_l};
        exp_w[2] = {8'h0, ev_l};
        exp_w[3] = {28'h0, emap};
        exp_w[4] = 32'(nc);
        for (int i = 0; i < nc; i++) begin
            exp_w[5 + 2*i] = vld[i] ? node_data[i*64 +: 32] : 32'h0;
            exp_w[6 + 2*i] = vld[i] ? node_data[i*64+32 +: 32] : 32'h0;
        end
        par = '0;
        for (int k = 1; k < len - 2; k++) par ^= exp_w[k];
        exp_w[len-2] = par;
        exp_w[len-1] = 32'hE0F0_0000;

        gcnt = 0;
        stall_en = stall;
        evt_req = 1'b1;
        @(posedge clk);
        #1 evt_req = 1'b0;
        busy = 0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (evt_ready) break;
            busy++;
            if (poke && busy == 3) begin
                evt_req = 1'b1;
                bcid_in = ~bc_l;
                evcnt_in = ~ev_l;
            end else begin
                evt_req = 1'b0;
            end
        end
        evt_req = 1'b0;
        stall_en = 1'b0;
        check(gcnt == len, "R9 frame length", 32'(gcnt), 32'(len));
        for (int k = 0; k < len && k < gcnt; k++) begin
            check(got[k] == exp_w[k], stall ? {tag_of(k, len), " R10 stalled"} :
                  (poke ? {tag_of(k, len), " R2 busy request"} : tag_of(k, len)), got[k], exp_w[k]);
        end
        if (!stall) check(busy == len, "R11 busy cycles", 32'(busy), 32'(len));
        repeat (3) @(negedge clk);
        check(gcnt == len && evt_ready, "R2 no extra frame after busy request", 32'(gcnt), 32'(len));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(evt_ready == 1'b1, "R1 ready in reset", 32'(evt_ready), 32'd1);
        check(word_we == 1'b0, "R1 no write in reset", 32'(word_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(evt_ready == 1'b1 && word_we == 1'b0, "R1 idle after reset", 32'(word_we), 32'd0);

        for (int n = 0; n <= 6; n++) begin
            for (int p = 0; p < 3; p++) begin
                run_frame(n, 4'(4'hA >> p) | 4'(n[0] ? 4'h8 : 4'h0), 4'(4'h4 << p),
                          (p == 1) ? 4'b1101 : 4'hF, p == 2, p == 1);
            end
        end
        for (int m = 0; m < 16; m++) begin
            run_frame(4, 4'(m), {4'(m)} ^ 4'h6, (m == 5 || m == 12) ? 4'b1011 : 4'hF,
                      m[0], m == 9);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule